// File: doc/BRIEF.md
# Framebuffer Pixel Write Formatter

This block takes rendered pixels carrying 8 bits for each of alpha, red, green and blue, and turns each one into the word that is stored in the frame store. A 3-bit format code chooses among eight output layouts. These layouts are 16-bit, 24-bit and 32-bit. Each layout has its own rule for where alpha comes from. The alpha can be a configured constant byte, a single bit from comparing the pixel alpha against a configured threshold, or the pixel alpha itself.

Each pixel also carries its screen x/y position. When dither is enabled and the chosen layout is 16-bit, a 4x4 ordered offset selected by that position is added to each colour channel before the channel is truncated.

Pixels come in on a valid/ready handshake. The packed word leaves through a registered valid/ready stage, together with the number of meaningful bytes in the word.

Top module: `fb_pix_pack`

## Requirements
- R1: Format 0 gives a 16-bit word. Bit 15 is bit 7 of the constant alpha byte. Bits 14:10, 9:5 and 4:0 are red, green and blue, each taken from the top 5 bits of its channel.
- R2: Format 1 gives a 16-bit word. Red is in bits 15:11 (top 5 bits), green in bits 10:5 (top 6 bits) and blue in bits 4:0 (top 5 bits). No alpha is stored.
- R3: Format 2 and format 7 both give a 16-bit word with alpha, red, green and blue in bits 15:12, 11:8, 7:4 and 3:0, each the top 4 bits of its channel. For equal inputs the two formats give identical output.
- R4: Format 3 gives a 16-bit word. Bit 15 is 1 when the pixel alpha is greater than or equal to the threshold input, and 0 otherwise. Bits 14:0 are packed as in format 0.
- R5: Format 4 puts red, green and blue unchanged in bits 23:16, 15:8 and 7:0. Bits 31:24 are zero.
- R6: Format 5 puts the constant alpha byte in bits 31:24 and the unchanged red, green and blue in bits 23:0.
- R7: Format 6 outputs the pixel unchanged as alpha, red, green, blue in bits 31:0.
- R8: The byte count output is 2 for formats 0, 1, 2, 3 and 7, 3 for format 4, and 4 for formats 5 and 6.
- R9: When dither is enabled in a 16-bit format, the bench first forms the Bayer value B from x bits 1:0 and y bits 1:0. Its bits 3..0 are x0^y0, y0, x1^y1 and y1. Each colour channel then has (B >> (4 - d)) added to it, where d is the number of low bits that are truncated from that channel. The sum saturates at 255 before truncation. Alpha is never dithered.
- R10: Dither has no effect on the output when it is disabled, and it has no effect in formats 4, 5 and 6.
- R11: The output is registered. A pixel accepted at a clock edge appears on the output at that same edge. While the output is valid and not taken, it holds steady. The input ready signal is high when the output is empty or is being taken.
- R12: In the 16-bit formats, bits 31:16 of the output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Block can accept a pixel |
| pix_argb_i | input | 32 | Pixel: alpha 31:24, red 23:16, green 15:8, blue 7:0 |
| pix_x_i | input | COORD_W | Screen x of the pixel |
| pix_y_i | input | COORD_W | Screen y of the pixel |
| fmt_i | input | 3 | Output format code |
| const_alpha_i | input | 8 | Constant alpha byte |
| alpha_thresh_i | input | 8 | Alpha threshold for format 3 |
| dither_en_i | input | 1 | Dither enable |
| out_valid_o | output | 1 | Packed word valid |
| out_ready_i | input | 1 | Downstream takes the word |
| out_data_o | output | 32 | Packed word |
| out_bytes_o | output | 3 | Meaningful bytes in the word |

## Verification
Every packed result comes from a single register. The word and byte count for a pixel accepted at a rising edge are therefore present from just after that edge. The bench drives each pixel at a falling edge and samples the result at the next falling edge, which is half a cycle after the capturing edge. In the stall sequence the bench samples at several falling edges in a row. These samples confirm that the word is held and that a second pixel presented during the stall appears only in the cycle after the downstream stage takes the first word.

// File: rtl/fb_pack_pkg.sv
package fb_pack_pkg;
  localparam int unsigned CH_W  = 8;
  localparam int unsigned PIX_W = 4 * CH_W;

  typedef enum logic [2:0] {
    FMT_X555  = 3'd0,
    FMT_565   = 3'd1,
    FMT_4444  = 3'd2,
    FMT_1555  = 3'd3,
    FMT_888   = 3'd4,
    FMT_X888  = 3'd5,
    FMT_8888  = 3'd6,
    FMT_4444B = 3'd7
  } fmt_e;

  function automatic logic [3:0] bayer_at(logic [1:0] x, logic [1:0] y);
    logic [3:0] v;
    unique case ({y, x})
      4'h0: v = 4'd0;  4'h1: v = 4'd8;  4'h2: v = 4'd2;  4'h3: v = 4'd10;
      4'h4: v = 4'd12; 4'h5: v = 4'd4;  4'h6: v = 4'd14; 4'h7: v = 4'd6;
      4'h8: v = 4'd3;  4'h9: v = 4'd11; 4'hA: v = 4'd1;  4'hB: v = 4'd9;
      4'hC: v = 4'd15; 4'hD: v = 4'd7;  4'hE: v = 4'd13; default: v = 4'd5;
    endcase
    return v;
  endfunction

  function automatic logic is_short(fmt_e f);
    return (f == FMT_X555) || (f == FMT_565) || (f == FMT_4444) ||
           (f == FMT_1555) || (f == FMT_4444B);
  endfunction

  function automatic logic [2:0] byte_count(fmt_e f);
    logic [2:0] n;
    case (f)
      FMT_888:           n = 3'd3;
      FMT_X888, FMT_8888: n = 3'd4;
      default:           n = 3'd2;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/fb_dither_chan.sv
module fb_dither_chan #(
  parameter int unsigned CH_W = 8
) (
  input  logic [CH_W-1:0] chan_i,
  input  logic [3:0]      bayer_i,
  input  logic [2:0]      drop_i,
  input  logic            en_i,
  output logic [CH_W-1:0] chan_o
);
  logic [3:0]    off;
  logic [CH_W:0] sum;

  always_comb begin
    case (drop_i)
      3'd2:    off = bayer_i >> 2;
      3'd3:    off = bayer_i >> 1;
      default: off = bayer_i;
    endcase
    sum = {1'b0, chan_i} + {{(CH_W-3){1'b0}}, off};
    if (!en_i)       chan_o = chan_i;
    else if (sum[CH_W]) chan_o = {CH_W{1'b1}};
    else             chan_o = sum[CH_W-1:0];
  end
endmodule

// File: rtl/fb_dither.sv
module fb_dither
  import fb_pack_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic [PIX_W-1:0]   pix_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  fmt_e               fmt_i,
  input  logic               en_i,
  output logic [PIX_W-1:0]   pix_o
);
  logic [3:0] bayer;
  logic       active;
  logic [2:0] drop [3];

  assign bayer  = bayer_at(x_i[1:0], y_i[1:0]);
  assign active = en_i && is_short(fmt_i);

  // index 0 = blue, 1 = green, 2 = red
  always_comb begin
    for (int c = 0; c < 3; c++) begin
      if (fmt_i == FMT_4444 || fmt_i == FMT_4444B) drop[c] = 3'd4;
      else if (fmt_i == FMT_565 && c == 1)         drop[c] = 3'd2;
      else                                         drop[c] = 3'd3;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : g_chan
    fb_dither_chan #(.CH_W(CH_W)) chan_i (
      .chan_i (pix_i[c*CH_W +: CH_W]),
      .bayer_i(bayer),
      .drop_i (drop[c]),
      .en_i   (active),
      .chan_o (pix_o[c*CH_W +: CH_W])
    );
  end

  assign pix_o[3*CH_W +: CH_W] = pix_i[3*CH_W +: CH_W];
endmodule

// File: rtl/fb_fmt_encode.sv
module fb_fmt_encode
  import fb_pack_pkg::*;
(
  input  logic [PIX_W-1:0] pix_i,
  input  fmt_e             fmt_i,
  input  logic [CH_W-1:0]  const_alpha_i,
  input  logic [CH_W-1:0]  alpha_thresh_i,
  output logic [PIX_W-1:0] data_o,
  output logic [2:0]       bytes_o
);
  logic [7:0] a, r, g, b;
  logic       a_bit;

  assign {a, r, g, b} = pix_i;
  assign a_bit        = (a >= alpha_thresh_i);
  assign bytes_o      = byte_count(fmt_i);

  always_comb begin
    data_o = '0;
    unique case (fmt_i)
      FMT_X555:            data_o[15:0] = {const_alpha_i[7], r[7:3], g[7:3], b[7:3]};
      FMT_565:             data_o[15:0] = {r[7:3], g[7:2], b[7:3]};
      FMT_4444, FMT_4444B: data_o[15:0] = {a[7:4], r[7:4], g[7:4], b[7:4]};
      FMT_1555:            data_o[15:0] = {a_bit, r[7:3], g[7:3], b[7:3]};
      FMT_888:             data_o[23:0] = {r, g, b};
      FMT_X888:            data_o       = {const_alpha_i, r, g, b};
      default:             data_o       = pix_i;
    endcase
  end
endmodule

// File: rtl/fb_out_stage.sv
module fb_out_stage #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  bytes_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  bytes_o
);
  assign in_ready_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
      bytes_o     <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        data_o  <= data_i;
        bytes_o <= bytes_i;
      end
    end
  end
endmodule

// File: rtl/fb_pix_pack.sv
module fb_pix_pack
  import fb_pack_pkg::*;
#(
  parameter int unsigned COORD_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [31:0]        pix_argb_i,
  input  logic [COORD_W-1:0] pix_x_i,
  input  logic [COORD_W-1:0] pix_y_i,
  input  logic [2:0]         fmt_i,
  input  logic [7:0]         const_alpha_i,
  input  logic [7:0]         alpha_thresh_i,
  input  logic               dither_en_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [31:0]        out_data_o,
  output logic [2:0]         out_bytes_o
);
  fmt_e             fmt;
  logic [PIX_W-1:0] pix_d;
  logic [PIX_W-1:0] packed_w;
  logic [2:0]       bytes_w;

  assign fmt = fmt_e'(fmt_i);

  fb_dither #(.COORD_W(COORD_W)) dither_i (
    .pix_i (pix_argb_i),
    .x_i   (pix_x_i),
    .y_i   (pix_y_i),
    .fmt_i (fmt),
    .en_i  (dither_en_i),
    .pix_o (pix_d)
  );

  fb_fmt_encode encode_i (
    .pix_i         (pix_d),
    .fmt_i         (fmt),
    .const_alpha_i (const_alpha_i),
    .alpha_thresh_i(alpha_thresh_i),
    .data_o        (packed_w),
    .bytes_o       (bytes_w)
  );

  fb_out_stage #(.DATA_W(PIX_W), .CNT_W(3)) stage_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .data_i     (packed_w),
    .bytes_i    (bytes_w),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .data_o     (out_data_o),
    .bytes_o    (out_bytes_o)
  );
endmodule

// File: rtl/fb_pix_pack_chk.sv
module fb_pix_pack_chk #(
  parameter int unsigned COORD_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [31:0]        pix_argb_i,
  input logic [COORD_W-1:0] pix_x_i,
  input logic [COORD_W-1:0] pix_y_i,
  input logic [2:0]         fmt_i,
  input logic [7:0]         const_alpha_i,
  input logic [7:0]         alpha_thresh_i,
  input logic               dither_en_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [31:0]        out_data_o,
  input logic [2:0]         out_bytes_o
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  AST_ACCEPT_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o); // R11

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_bytes_o))); // R11

  AST_EMPTY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o); // R11

  AST_BYTES_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_bytes_o == 3'd2 || out_bytes_o == 3'd3 || out_bytes_o == 3'd4)); // R8

  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_bytes_o == 3'd2) |-> (out_data_o[31:16] == 16'h0)); // R12

  AST_X888_ALPHA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && fmt_i == 3'd5) |=> (out_data_o[31:24] == $past(const_alpha_i))); // R6

  AST_8888_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && fmt_i == 3'd6) |=> (out_data_o == $past(pix_argb_i))); // R7
endmodule

bind fb_pix_pack fb_pix_pack_chk #(.COORD_W(COORD_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .pix_argb_i    (pix_argb_i),
  .pix_x_i       (pix_x_i),
  .pix_y_i       (pix_y_i),
  .fmt_i         (fmt_i),
  .const_alpha_i (const_alpha_i),
  .alpha_thresh_i(alpha_thresh_i),
  .dither_en_i   (dither_en_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_data_o    (out_data_o),
  .out_bytes_o   (out_bytes_o)
);

// File: tb/fb_pix_pack_tb_top.sv
`timescale 1ns/1ps
module fb_pix_pack_tb_top;
  localparam int unsigned COORD_W = 12;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               in_valid_i = 1'b0;
  logic               in_ready_o;
  logic [31:0]        pix_argb_i = '0;
  logic [COORD_W-1:0] pix_x_i = '0;
  logic [COORD_W-1:0] pix_y_i = '0;
  logic [2:0]         fmt_i = '0;
  logic [7:0]         const_alpha_i = 8'hA5;
  logic [7:0]         alpha_thresh_i = 8'h80;
  logic               dither_en_i = 1'b0;
  logic               out_valid_o;
  logic               out_ready_i = 1'b1;
  logic [31:0]        out_data_o;
  logic [2:0]         out_bytes_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  fb_pix_pack #(.COORD_W(COORD_W)) dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dith(logic [7:0] c, int drop, logic [3:0] bv, bit on);
    int s;
    if (!on) return c;
    s = int'(c) + int'(bv >> (4 - drop));
    return (s > 255) ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [31:0] model(int f, logic [31:0] p, logic [7:0] ca,
                                        logic [7:0] th, bit den, int x, int y);
    logic [7:0] a, r, g, b;
    logic [3:0] bv;
    bit         on;
    int         dr, dg;
    {a, r, g, b} = p;
    bv = {x[0] ^ y[0], y[0], x[1] ^ y[1], y[1]};
    on = den && (f < 4 || f == 7);
    dr = (f == 2 || f == 7) ? 4 : 3;
    dg = (f == 1) ? 2 : dr;
    r = dith(r, dr, bv, on);
    g = dith(g, dg, bv, on);
    b = dith(b, dr, bv, on);
    case (f)
      0:    return {16'h0, ca[7], r[7:3], g[7:3], b[7:3]};
      1:    return {16'h0, r[7:3], g[7:2], b[7:3]};
      2, 7: return {16'h0, a[7:4], r[7:4], g[7:4], b[7:4]};
      3:    return {16'h0, (a >= th), r[7:3], g[7:3], b[7:3]};
      4:    return {8'h0, r, g, b};
      5:    return {ca, r, g, b};
      default: return p;
    endcase
  endfunction

  function automatic string req_of(int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2, 7: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic send_check(int f, logic [31:0] p, bit den, int x, int y);
    @(negedge clk_i);
    fmt_i = f[2:0]; pix_argb_i = p; dither_en_i = den;
    pix_x_i = COORD_W'(x); pix_y_i = COORD_W'(y);
    in_valid_i = 1'b1; out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R11", {31'h0, out_valid_o}, 32'h1);
    if (den && (f < 4 || f == 7))
      check({req_of(f), " R9"}, out_data_o, model(f, p, const_alpha_i, alpha_thresh_i, den, x, y));
    else if (den)
      check({req_of(f), " R10"}, out_data_o, model(f, p, const_alpha_i, alpha_thresh_i, 1'b0, x, y));
    else
      check({req_of(f), " R10"}, out_data_o, model(f, p, const_alpha_i, alpha_thresh_i, 1'b0, x, y));
    check("R8", {29'h0, out_bytes_o}, (f == 4) ? 32'd3 : (f == 5 || f == 6) ? 32'd4 : 32'd2);
    if (f < 4 || f == 7) check("R12", {16'h0, out_data_o[31:16]}, 32'h0);
  endtask

  logic [31:0] pats [5] = '{32'hFFFF_FFFF, 32'h807C_3A05, 32'h7F12_F9C8,
                             32'h0000_0000, 32'h81FB_FEFA};

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL R11 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] m2, m7;
    repeat (3) @(negedge clk_i);
    check("R11", {30'h0, out_valid_o, in_ready_o}, 32'h1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11", {30'h0, out_valid_o, in_ready_o}, 32'h1);

    for (int f = 0; f < 8; f++)
      for (int d = 0; d < 2; d++)
        for (int y = 0; y < 4; y++)
          for (int x = 0; x < 4; x++)
            for (int k = 0; k < 5; k++)
              send_check(f, pats[k], bit'(d), x + 4 * k, y + 8);

    // R4 boundary: alpha equal to threshold and one below
    alpha_thresh_i = 8'h7F;
    send_check(3, 32'h7F00_0000, 1'b0, 0, 0);
    check("R4", {31'h0, out_data_o[15]}, 32'h1);
    send_check(3, 32'h7E00_0000, 1'b0, 0, 0);
    check("R4", {31'h0, out_data_o[15]}, 32'h0);
    alpha_thresh_i = 8'h80;

    // R3 direct comparison of format 7 against format 2
    send_check(2, 32'h9A3C_5E71, 1'b1, 1, 2);
    m2 = out_data_o;
    send_check(7, 32'h9A3C_5E71, 1'b1, 1, 2);
    m7 = out_data_o;
    check("R3", m7, m2);

    // R9 saturation: white with largest Bayer offset stays all ones
    send_check(1, 32'h00FF_FFFF, 1'b1, 0, 3);
    check("R9", out_data_o, 32'h0000_FFFF);

    // R11 stall sequence
    @(negedge clk_i);
    out_ready_i = 1'b0; fmt_i = 3'd6; dither_en_i = 1'b0;
    pix_argb_i = 32'h1122_3344; in_valid_i = 1'b1;
    @(negedge clk_i);
    pix_argb_i = 32'h5566_7788;
    check("R11", {31'h0, in_ready_o}, 32'h0);
    for (int i = 0; i < 3; i++) begin
      check("R11", out_data_o, 32'h1122_3344);
      check("R11", {31'h0, out_valid_o}, 32'h1);
      @(negedge clk_i);
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check("R11", out_data_o, 32'h5566_7788);
    check("R11", {31'h0, out_valid_o}, 32'h1);
    @(negedge clk_i);
    check("R11", {31'h0, out_valid_o}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule